// File: doc/BRIEF.md
# Conversion Sequencer with Internal Serial Burst

This block is the digital control side of a successive-approximation sampling converter. Two active-low strobes, a chip select and a read/convert line, are merged by logical OR. The moment both are low (that is, the falling edge of whichever drops second) starts a conversion. A busy flag drops for a fixed number of system clocks while a stand-in for the analog core holds the sampled word. At the end of that window the word is moved into a result register and busy rises again, which is when acquisition of the next sample begins.

In internal-clock mode every accepted start also launches a serial burst. After a fixed delay the block generates 16 pulses on its own serial clock and sends the result of the previous conversion MSB first. The word is sent either as straight binary or as two's complement. After the burst the data line is parked at the tag level captured when the burst was launched. The power-down input blocks new conversions and preserves the held result. A flag marks the first result after reset as invalid.

The serial output is a fixed-rate stream without back-pressure. Once a burst is launched it runs to completion, and a receiver cannot stall it. For that reason the pins are plain and there is no valid/ready pair.

Top module: `sar_seq_ctrl`

## Requirements
- R1: A conversion starts only when the OR of `cs_n` and `rc_n` falls, in either order. With only one strobe low, busy stays high.
- R2: `busy` falls on the third rising clock edge after the second strobe falls (two synchronizer flops plus edge detection). It stays low for exactly CONV_CYC cycles and rises in the same cycle the new result is loaded.
- R3: A combined-strobe falling edge that occurs while `busy` is low is ignored. The low window is not extended and no second burst is launched.
- R4: While `pwrdn` is high, start requests are ignored. Busy stays high, no burst appears, and the held result is unchanged, as shown by the next burst.
- R5: In internal mode (`ext_clk_sel` low) each accepted start produces exactly 16 `sclk` pulses. `sclk` is low whenever no burst is in progress.
- R6: The burst carries the result of the preceding conversion, MSB first. Each bit is stable across its rising and the following falling `sclk` edge.
- R7: The first `sclk` rise comes BURST_DLY + SCLK_LO/2 cycles after `busy` is first seen low.
- R8: After the 16th bit, `sdata` holds the `tag_in` level that was sampled at launch, until the next burst.
- R9: With `fmt_straight` high the word is sent unchanged (straight binary). With it low, bit 15 is inverted (two's complement), so midscale 0x8000 is sent as 0x0000.
- R10: With `ext_clk_sel` high, conversions still run for CONV_CYC cycles, but no `sclk` pulse is produced and `sdata` does not move.
- R11: `first_word_bad` is 1 after reset and after the first conversion. It clears to 0 when the second conversion completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rc_n | input | 1 | Read/convert strobe, active low |
| pwrdn | input | 1 | Power-down; blocks conversions |
| ext_clk_sel | input | 1 | 1 = external read clock (no internal burst) |
| fmt_straight | input | 1 | 1 = straight binary, 0 = two's complement |
| tag_in | input | 1 | Level parked on sdata after a burst |
| sample_word | input | WORD_W | Stand-in analog sample, straight binary |
| busy | output | 1 | Low while a conversion is in progress |
| sclk | output | 1 | Internally generated serial clock |
| sdata | output | 1 | Serial data |
| first_word_bad | output | 1 | Held result is not a valid conversion |

## Verification
The bench builds the block with CONV_CYC=60, BURST_DLY=3, SCLK_HI=1 and SCLK_LO=2. This gives a 3-cycle bit period, and the whole 16-bit burst plus its delay fits well inside a single conversion. With these values the exact first-rise cycle, the busy-low window and a mid-conversion retrigger can all be observed within a few dozen cycles per conversion. Many randomized conversions, both strobe orders, both formats, power-down and external mode therefore fit easily in the run.

// File: rtl/sarseq_pkg.sv
package sarseq_pkg;
  typedef enum logic [1:0] {SB_IDLE, SB_WAIT, SB_SHIFT} burst_st_t;
  localparam int SY_CS  = 0;
  localparam int SY_RC  = 1;
  localparam int SY_PD  = 2;
  localparam int SY_EXT = 3;
  localparam int SY_FMT = 4;
  localparam int SY_TAG = 5;
  localparam int SY_N   = 6;
endpackage

// File: rtl/sarseq_sync.sv
module sarseq_sync #(
  parameter int W = 6,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= {STAGES{RST_VAL}};
    else        pipe <= {pipe[STAGES-2:0], d};
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/sarseq_conv.sv
module sarseq_conv #(
  parameter int W = 16,
  parameter int CONV_CYC = 110
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         comb_s,
  input  logic         pd_s,
  input  logic [W-1:0] sample,
  output logic         start_o,
  output logic         busy_o,
  output logic [W-1:0] result_o,
  output logic         first_bad_o
);
  localparam int CW = $clog2(CONV_CYC + 1);

  logic         comb_d, busy_q, seen_q, bad_q;
  logic [CW-1:0] cnt_q;
  logic [W-1:0] held_q, res_q;
  logic         fall;

  assign fall    = comb_d & ~comb_s;
  assign start_o = fall & busy_q & ~pd_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      comb_d <= 1'b1;
      busy_q <= 1'b1;
      cnt_q  <= '0;
      held_q <= '0;
      res_q  <= '0;
      seen_q <= 1'b0;
      bad_q  <= 1'b1;
    end else begin
      comb_d <= comb_s;
      if (start_o) begin
        busy_q <= 1'b0;
        cnt_q  <= CW'(CONV_CYC - 1);
        held_q <= sample;
      end else if (!busy_q) begin
        if (cnt_q == '0) begin
          busy_q <= 1'b1;
          res_q  <= held_q;
          bad_q  <= ~seen_q;
          seen_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign busy_o      = busy_q;
  assign result_o    = res_q;
  assign first_bad_o = bad_q;

  // checker state: length of the current busy-low window
  logic [CW-1:0] lowcnt_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lowcnt_q <= '0;
    else if (busy_q) lowcnt_q <= '0;
    else             lowcnt_q <= lowcnt_q + 1'b1;
  end

  // R2
  load_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> res_q == $past(held_q));
  // R3
  busy_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> lowcnt_q < CW'(CONV_CYC));
  // R4
  pwrdn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_s && busy_q) |=> (busy_q && $stable(res_q)));
  // R11
  first_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bad_q) |-> $rose(busy_q));
endmodule

// File: rtl/sarseq_burst.sv
module sarseq_burst
  import sarseq_pkg::*;
#(
  parameter int W = 16,
  parameter int BURST_DLY = 14,
  parameter int SCLK_HI = 3,
  parameter int SCLK_LO = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         launch,
  input  logic [W-1:0] word,
  input  logic         tag_lvl,
  output logic         sclk,
  output logic         sdata
);
  localparam int LEAD = SCLK_LO / 2;
  localparam int BITP = SCLK_HI + SCLK_LO;
  localparam int PW   = $clog2(BITP + 1);
  localparam int BW   = $clog2(W);
  localparam int DW   = $clog2(BURST_DLY + 1);

  burst_st_t     st_q;
  logic [DW-1:0] dcnt_q;
  logic [PW-1:0] p_q;
  logic [BW-1:0] b_q;
  logic [W-1:0]  sh_q;
  logic          park_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SB_IDLE;
      dcnt_q <= '0;
      p_q    <= '0;
      b_q    <= '0;
      sh_q   <= '0;
      park_q <= 1'b0;
    end else begin
      case (st_q)
        SB_IDLE: if (launch) begin
          st_q   <= SB_WAIT;
          dcnt_q <= DW'(BURST_DLY - 1);
          sh_q   <= word;
          park_q <= tag_lvl;
        end
        SB_WAIT: if (dcnt_q == '0) begin
          st_q <= SB_SHIFT;
          p_q  <= '0;
          b_q  <= '0;
        end else begin
          dcnt_q <= dcnt_q - 1'b1;
        end
        SB_SHIFT: if (p_q == PW'(BITP - 1)) begin
          p_q <= '0;
          if (b_q == BW'(W - 1)) begin
            st_q <= SB_IDLE;
          end else begin
            b_q  <= b_q + 1'b1;
            sh_q <= {sh_q[W-2:0], 1'b0};
          end
        end else begin
          p_q <= p_q + 1'b1;
        end
        default: st_q <= SB_IDLE;
      endcase
    end
  end

  assign sclk  = (st_q == SB_SHIFT) && (p_q >= PW'(LEAD)) && (p_q < PW'(LEAD + SCLK_HI));
  assign sdata = (st_q == SB_SHIFT) ? sh_q[W-1] : park_q;

  // checker state: pulses seen in the current burst
  logic       sclk_d;
  logic [7:0] pcnt_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      pcnt_q <= '0;
    end else begin
      sclk_d <= sclk;
      if (launch)             pcnt_q <= '0;
      else if (sclk && !sclk_d) pcnt_q <= pcnt_q + 1'b1;
    end
  end

  // R5
  pulse_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SB_IDLE && $past(st_q) == SB_SHIFT) |-> pcnt_q == 8'(W));
  // R5
  launch_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> st_q == SB_IDLE);
  // R6
  bit_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk) |-> $stable(sdata));
  // R8
  park_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != SB_SHIFT && $past(st_q) != SB_SHIFT && !$past(launch)) |-> $stable(sdata));
endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
  import sarseq_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int CONV_CYC = 110,
  parameter int BURST_DLY = 14,
  parameter int SCLK_HI = 3,
  parameter int SCLK_LO = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rc_n,
  input  logic              pwrdn,
  input  logic              ext_clk_sel,
  input  logic              fmt_straight,
  input  logic              tag_in,
  input  logic [WORD_W-1:0] sample_word,
  output logic              busy,
  output logic              sclk,
  output logic              sdata,
  output logic              first_word_bad
);
  localparam logic [SY_N-1:0] SY_RST = SY_N'(3);

  logic [SY_N-1:0]   raw, syn;
  logic              start, launch;
  logic [WORD_W-1:0] result, tx_word;

  assign raw = {tag_in, fmt_straight, ext_clk_sel, pwrdn, rc_n, cs_n};

  sarseq_sync #(.W(SY_N), .STAGES(SYNC_STAGES), .RST_VAL(SY_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(syn));

  sarseq_conv #(.W(WORD_W), .CONV_CYC(CONV_CYC)) u_conv (
    .clk(clk), .rst_n(rst_n),
    .comb_s(syn[SY_CS] | syn[SY_RC]), .pd_s(syn[SY_PD]),
    .sample(sample_word), .start_o(start), .busy_o(busy),
    .result_o(result), .first_bad_o(first_word_bad));

  assign launch  = start & ~syn[SY_EXT];
  assign tx_word = syn[SY_FMT] ? result : {~result[WORD_W-1], result[WORD_W-2:0]};

  sarseq_burst #(.W(WORD_W), .BURST_DLY(BURST_DLY), .SCLK_HI(SCLK_HI), .SCLK_LO(SCLK_LO)) u_burst (
    .clk(clk), .rst_n(rst_n), .launch(launch), .word(tx_word),
    .tag_lvl(syn[SY_TAG]), .sclk(sclk), .sdata(sdata));
endmodule

// File: tb/sim_sar_seq_ctrl.sv
module sim_sar_seq_ctrl;
  localparam int W  = 16;
  localparam int CC = 60;
  localparam int BD = 3;
  localparam int SH = 1;
  localparam int SL = 2;
  localparam int RISE_AT = 2 + BD + SL / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, rc_n = 1'b1, pwrdn = 1'b0, ext_sel = 1'b0, fmt = 1'b1, tag = 1'b0;
  logic [W-1:0] sample = '0;
  logic busy, sclk, sdata, fbad;

  always #10 clk = ~clk;

  sar_seq_ctrl #(.WORD_W(W), .CONV_CYC(CC), .BURST_DLY(BD), .SCLK_HI(SH), .SCLK_LO(SL)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rc_n(rc_n), .pwrdn(pwrdn),
    .ext_clk_sel(ext_sel), .fmt_straight(fmt), .tag_in(tag), .sample_word(sample),
    .busy(busy), .sclk(sclk), .sdata(sdata), .first_word_bad(fbad));

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [W-1:0] model_res = '0;
  int n_done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] fmtw(input logic [W-1:0] v, input bit sb);
    return sb ? v : {~v[W-1], v[W-2:0]};
  endfunction

  task automatic run_conv(input logic [W-1:0] smp, input bit sb, input bit tg,
                          input bit ext, input bit cs_first, input bit retrig);
    int lowc = 0, pulses = 0, first_rise = -1, bad_hold = 0, moves = 0;
    logic prv = 1'b0, bitv = 1'b0, sd0;
    logic [W-1:0] got = '0;
    @(negedge clk);
    sample = smp; fmt = sb; tag = tg; ext_sel = ext; cs_n = 1'b1; rc_n = 1'b1;
    repeat (4) @(negedge clk);
    if (cs_first) cs_n = 1'b0; else rc_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy == 1'b1, "R1", "one strobe low must not start", busy, 1);
    if (cs_first) rc_n = 1'b0; else cs_n = 1'b0;
    sd0 = sdata;
    for (int i = 0; i <= CC + 8; i++) begin
      @(negedge clk);
      if (i == 1) chk(busy == 1'b1, "R2", "busy before third edge", busy, 1);
      if (i == 2) chk(busy == 1'b0, "R2", "busy at third edge", busy, 0);
      if (!busy) lowc++;
      if (sdata !== sd0) moves++;
      if (sclk && !prv) begin
        pulses++;
        if (first_rise < 0) first_rise = i;
        bitv = sdata;
        got = {got[W-2:0], sdata};
      end
      if (!sclk && prv && sdata !== bitv) bad_hold++;
      prv = sclk;
      if (retrig && i == 10) rc_n = 1'b1;
      if (retrig && i == 12) rc_n = 1'b0;
    end
    chk(lowc == CC, retrig ? "R3" : "R2", "busy low cycles", lowc, CC);
    chk(busy == 1'b1, "R2", "busy high after conversion", busy, 1);
    if (ext) begin
      chk(pulses == 0, "R10", "pulses in external mode", pulses, 0);
      chk(moves == 0, "R10", "sdata moves in external mode", moves, 0);
    end else begin
      chk(pulses == 16, retrig ? "R3" : "R5", "pulse count", pulses, 16);
      chk(first_rise == RISE_AT, "R7", "first rise cycle", first_rise, RISE_AT);
      chk(got == fmtw(model_res, sb), sb ? "R6" : "R9", "received word", got, fmtw(model_res, sb));
      chk(bad_hold == 0, "R6", "bit changed before falling edge", bad_hold, 0);
      chk(sdata == tg, "R8", "parked level", sdata, tg);
    end
    model_res = smp;
    n_done++;
    chk(fbad == (n_done < 2), "R11", "first word flag", fbad, (n_done < 2));
    cs_n = 1'b1; rc_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic run_pwrdn();
    int lows = 0, highs = 0, moves = 0;
    logic sd0;
    @(negedge clk);
    pwrdn = 1'b1;
    repeat (4) @(negedge clk);
    sd0 = sdata;
    cs_n = 1'b0; rc_n = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (!busy) lows++;
      if (sclk) highs++;
      if (sdata !== sd0) moves++;
    end
    chk(lows == 0, "R4", "busy fell in power-down", lows, 0);
    chk(highs == 0, "R4", "sclk active in power-down", highs, 0);
    chk(moves == 0, "R4", "sdata moved in power-down", moves, 0);
    cs_n = 1'b1; rc_n = 1'b1;
    repeat (3) @(negedge clk);
    pwrdn = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b1, "R2", "reset busy", busy, 1);
    chk(sclk == 1'b0, "R5", "reset sclk", sclk, 0);
    chk(fbad == 1'b1, "R11", "reset first flag", fbad, 1);
    run_conv(16'h1234, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    run_conv(16'h8000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    run_conv(16'hABCD, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);  // R9 midscale sent as 0000, R3 retrigger
    run_pwrdn();
    run_conv(16'h0F0F, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);  // R4: burst must carry ABCD
    run_conv(16'h5555, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);  // R10
    run_conv(16'hFFFF, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    for (int k = 0; k < 10; k++) begin
      run_conv(W'($urandom), 1'($urandom), 1'($urandom), 1'b0, 1'($urandom), 1'($urandom));
    end
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end
endmodule